// File: doc/BRIEF.md
# Quad-channel UART host bus interface

This block sits between a host processor bus and the four serial channels of a UART. The host presents an active-low chip select, separate active-low read and write strobes, an active-low interrupt acknowledge, a 6-bit address and an 8-bit data word. The block samples these lines once into the local clock domain. It decodes the address against two separate maps, one for reads and one for writes. For each access it issues a single-cycle register strobe to the channel and global back end, and it returns an active-low data acknowledge. On reads and interrupt acknowledges it drives the bus.

Several write addresses carry no register behind them. They act as command strobes that change global state: entering and leaving power-down, turning the acknowledge output off and on, and halving the core clock rate. One address sets the baud-rate range. Each channel's mode address reaches one of three mode registers through a per-channel pointer. The pointer travels with every back-end strobe, so the back end knows which mode register is meant.

Top module: `quart_host_if`

## Requirements
- R1: After reset, `ack_n` is 1, `rdata_oe` is 0, `pwr_down`, `clk_div2` and `baud_hi` are 0, `ack_en` is 1, `core_ce` is 1, and every channel's mode pointer is 1 (MR1).
- R2: An access exists only while `cs_n` is 0 together with `rd_n` or `wr_n` at 0. Inputs are registered once. In the next cycle, exactly one single-cycle `be_rd` or `be_wr` pulse is issued with `be_addr` equal to the address and `be_wdata` equal to the data. One cycle later `ack_n` falls. On a read, `rdata` then holds `be_rdata`. A strobe held for several cycles produces only one pulse.
- R3: Reads and writes use separate maps. Channel offset 2 is a reserved read and a forwarded write. The top offset of channels b and d (0x0F, 0x1F) is a reserved write and a forwarded read. 0x28 and 0x30 to 0x3F are reserved writes. 0x24 to 0x27 and 0x2D to 0x3F are reserved reads. A reserved read returns 0x00 with no back-end strobe. A reserved write has no strobe and no effect, but is still acknowledged.
- R4: `ack_n` returns to 1, and `rdata_oe` to 0, two cycles after the strobes go inactive. `rdata_oe` is set only for reads and interrupt acknowledges, never for writes.
- R5: A write to 0x26 clears `ack_en`. While `ack_en` is 0, accesses still take effect but `ack_n` stays 1, and this includes the 0x26 write itself. A write to 0x27 sets `ack_en`, and that write is acknowledged.
- R6: A write to 0x24 sets `pwr_down` and a write to 0x25 clears it, whatever the data. Neither produces a back-end strobe.
- R7: A write to 0x2E sets `clk_div2`, and `core_ce` then alternates every cycle. A write to 0x2F clears it, and `core_ce` then stays 1 from the next cycle on.
- R8: When `cs_n` is 1 and `iack_n` is 0, the block pulses `cir_upd` once, drives `irq_vec` on `rdata` with `rdata_oe` set, and acknowledges. When `cs_n` is 0, `iack_n` alone starts nothing.
- R9: A read or write at channel offset 0 carries that channel's current pointer on `be_mr_sel` (0 = MR0, 1 = MR1, 2 = MR2). The pointer then advances by one, saturates at 2, and is kept separately for each channel.
- R10: A write to channel offset 2 whose upper nibble is 0x1 sets that channel's pointer to 1. An upper nibble of 0xB sets it to 0. The write is still forwarded to the back end.
- R11: A write to 0x2D sets `baud_hi` to data bit 0. It produces no back-end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| addr | input | 6 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |
| ack_n | output | 1 | Data acknowledge, active low |
| irq_vec | input | 8 | Interrupt vector from the arbitration logic |
| cir_upd | output | 1 | One-cycle pulse to update the current interrupt register |
| be_rd | output | 1 | Back-end register read pulse |
| be_wr | output | 1 | Back-end register write pulse |
| be_addr | output | 6 | Back-end register address |
| be_mr_sel | output | 2 | Mode register selected by the channel pointer |
| be_wdata | output | 8 | Back-end write data |
| be_rdata | input | 8 | Back-end read data for `be_addr` |
| pwr_down | output | 1 | Power-down state |
| ack_en | output | 1 | Acknowledge output enabled |
| clk_div2 | output | 1 | Core clock halved |
| baud_hi | output | 1 | High baud-rate range |
| core_ce | output | 1 | Clock enable for divided core logic |

## Verification
The bench builds the block with its defaults: four channels, an 8-register span per channel, a 6-bit address and 8-bit data. With these values every channel window, the full global area from 0x20 to 0x2F and the reserved area above it can all be addressed. So all four mode pointers can be driven separately, and every command strobe can be issued alongside the reserved addresses on both maps. The back-end read data is modelled as a function of `be_addr` and `be_mr_sel`. A returned value therefore shows both which register was reached and which mode register the pointer selected.

// File: rtl/quart_pkg.sv
package quart_pkg;

  typedef enum logic [3:0] {
    AK_NONE,
    AK_BACKEND,
    AK_PDOWN,
    AK_PUP,
    AK_ACK_OFF,
    AK_ACK_ON,
    AK_DIV2,
    AK_DIV1,
    AK_BAUD
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_HOLD
  } bus_st_e;

  // global area offsets relative to the first address above the channels
  localparam int G_BCR_LAST = 3;
  localparam int G_PDOWN    = 4;
  localparam int G_PUP      = 5;
  localparam int G_ACKOFF   = 6;
  localparam int G_ACKON    = 7;
  localparam int G_RSV_W    = 8;
  localparam int G_RD_LO    = 8;
  localparam int G_RD_HI    = 12;
  localparam int G_BAUD     = 13;
  localparam int G_DIV2     = 14;
  localparam int G_DIV1     = 15;

  // channel-local offsets
  localparam int OFF_MODE = 0;
  localparam int OFF_CMD  = 2;

  localparam logic [1:0] MR0 = 2'd0;
  localparam logic [1:0] MR1 = 2'd1;
  localparam logic [1:0] MR2 = 2'd2;

  localparam logic [3:0] PCMD_MR1 = 4'h1;
  localparam logic [3:0] PCMD_MR0 = 4'hB;

endpackage

// File: rtl/quart_bus_sync.sv
module quart_bus_sync #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iack_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              s_cs_n,
  output logic              s_rd_n,
  output logic              s_wr_n,
  output logic              s_iack_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cs_n   <= 1'b1;
      s_rd_n   <= 1'b1;
      s_wr_n   <= 1'b1;
      s_iack_n <= 1'b1;
      s_addr   <= '0;
      s_data   <= '0;
    end else begin
      s_cs_n   <= cs_n;
      s_rd_n   <= rd_n;
      s_wr_n   <= wr_n;
      s_iack_n <= iack_n;
      s_addr   <= addr;
      s_data   <= wdata;
    end
  end

endmodule

// File: rtl/quart_decode.sv
module quart_decode
  import quart_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int N_CH   = 4,
  parameter int SPAN_W = 3,
  parameter int CH_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output acc_kind_e         kind,
  output logic              is_chan,
  output logic [CH_W-1:0]   chan,
  output logic [SPAN_W-1:0] off
);

  localparam logic [ADDR_W-1:0] GLOB_BASE = ADDR_W'(N_CH << SPAN_W);

  logic [ADDR_W-1:0] g;

  always_comb begin
    is_chan = (addr < GLOB_BASE);
    chan    = CH_W'(addr >> SPAN_W);
    off     = addr[SPAN_W-1:0];
    g       = addr - GLOB_BASE;
    kind    = AK_NONE;
    if (is_chan) begin
      if (!is_write) begin
        kind = (off == SPAN_W'(OFF_CMD)) ? AK_NONE : AK_BACKEND;
      end else begin
        kind = (chan[0] && (off == '1)) ? AK_NONE : AK_BACKEND;
      end
    end else if (!is_write) begin
      if ((g <= ADDR_W'(G_BCR_LAST)) ||
          ((g >= ADDR_W'(G_RD_LO)) && (g <= ADDR_W'(G_RD_HI))))
        kind = AK_BACKEND;
    end else begin
      if (g <= ADDR_W'(G_BCR_LAST))                   kind = AK_BACKEND;
      else if (g == ADDR_W'(G_PDOWN))                 kind = AK_PDOWN;
      else if (g == ADDR_W'(G_PUP))                   kind = AK_PUP;
      else if (g == ADDR_W'(G_ACKOFF))                kind = AK_ACK_OFF;
      else if (g == ADDR_W'(G_ACKON))                 kind = AK_ACK_ON;
      else if (g == ADDR_W'(G_RSV_W))                 kind = AK_NONE;
      else if (g <= ADDR_W'(G_RD_HI))                 kind = AK_BACKEND;
      else if (g == ADDR_W'(G_BAUD))                  kind = AK_BAUD;
      else if (g == ADDR_W'(G_DIV2))                  kind = AK_DIV2;
      else if (g == ADDR_W'(G_DIV1))                  kind = AK_DIV1;
    end
  end

endmodule

// File: rtl/quart_mr_ptr.sv
module quart_mr_ptr
  import quart_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            load,
  input  logic [1:0]      ld_val,
  input  logic [CH_W-1:0] chan,
  output logic [1:0]      cur
);

  logic [N_CH-1:0][1:0] ptr;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr[i] <= MR1;
      end else if (chan == CH_W'(i)) begin
        if (load)
          ptr[i] <= ld_val;
        else if (step && (ptr[i] != MR2))
          ptr[i] <= ptr[i] + 2'd1;
      end
    end
  end

  assign cur = ptr[chan];

endmodule

// File: rtl/quart_glob_ctl.sv
module quart_glob_ctl
  import quart_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fire,
  input  acc_kind_e kind,
  input  logic      dbit0,
  output logic      pwr_down,
  output logic      ack_en,
  output logic      clk_div2,
  output logic      baud_hi,
  output logic      core_ce
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_down <= 1'b0;
      ack_en   <= 1'b1;
      clk_div2 <= 1'b0;
      baud_hi  <= 1'b0;
    end else if (fire) begin
      case (kind)
        AK_PDOWN:   pwr_down <= 1'b1;
        AK_PUP:     pwr_down <= 1'b0;
        AK_ACK_OFF: ack_en   <= 1'b0;
        AK_ACK_ON:  ack_en   <= 1'b1;
        AK_DIV2:    clk_div2 <= 1'b1;
        AK_DIV1:    clk_div2 <= 1'b0;
        AK_BAUD:    baud_hi  <= dbit0;
        default:    ;
      endcase
    end
  end

  // enable for logic on the divisible clock; baud and change detectors stay undivided
  always_ff @(posedge clk) begin
    if (rst)
      core_ce <= 1'b1;
    else if (clk_div2)
      core_ce <= ~core_ce;
    else
      core_ce <= 1'b1;
  end

endmodule

// File: rtl/quart_host_if.sv
module quart_host_if
  import quart_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int N_CH   = 4,
  parameter int SPAN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iack_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              ack_n,
  input  logic [DATA_W-1:0] irq_vec,
  output logic              cir_upd,
  output logic              be_rd,
  output logic              be_wr,
  output logic [ADDR_W-1:0] be_addr,
  output logic [1:0]        be_mr_sel,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              pwr_down,
  output logic              ack_en,
  output logic              clk_div2,
  output logic              baud_hi,
  output logic              core_ce
);

  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic              s_cs_n, s_rd_n, s_wr_n, s_iack_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;

  quart_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .iack_n(iack_n),
    .addr(addr), .wdata(wdata),
    .s_cs_n(s_cs_n), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .s_iack_n(s_iack_n),
    .s_addr(s_addr), .s_data(s_data)
  );

  logic acc_rd, acc_wr, iack_cyc, active;
  assign acc_rd   = ~s_cs_n & ~s_rd_n;
  assign acc_wr   = ~s_cs_n & ~s_wr_n & s_rd_n;
  assign iack_cyc = s_cs_n & ~s_iack_n;
  assign active   = acc_rd | acc_wr | iack_cyc;

  acc_kind_e         kind;
  logic              is_chan;
  logic [CH_W-1:0]   chan;
  logic [SPAN_W-1:0] off;

  quart_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH), .SPAN_W(SPAN_W), .CH_W(CH_W)) u_dec (
    .addr(s_addr), .is_write(acc_wr),
    .kind(kind), .is_chan(is_chan), .chan(chan), .off(off)
  );

  bus_st_e st;
  logic    start;
  assign start = (st == ST_IDLE) && active;

  logic       ptr_step, ptr_load;
  logic [3:0] nib;
  logic [1:0] ptr_cur;
  assign nib      = s_data[DATA_W-1 -: 4];
  assign ptr_step = start && (acc_rd | acc_wr) && is_chan && (off == SPAN_W'(OFF_MODE));
  assign ptr_load = start && acc_wr && is_chan && (off == SPAN_W'(OFF_CMD)) &&
                    ((nib == PCMD_MR1) || (nib == PCMD_MR0));

  quart_mr_ptr #(.N_CH(N_CH), .CH_W(CH_W)) u_ptr (
    .clk(clk), .rst(rst),
    .step(ptr_step), .load(ptr_load),
    .ld_val((nib == PCMD_MR0) ? MR0 : MR1),
    .chan(chan), .cur(ptr_cur)
  );

  quart_glob_ctl u_glob (
    .clk(clk), .rst(rst),
    .fire(start && acc_wr), .kind(kind), .dbit0(s_data[0]),
    .pwr_down(pwr_down), .ack_en(ack_en), .clk_div2(clk_div2),
    .baud_hi(baud_hi), .core_ce(core_ce)
  );

  logic op_rd, op_iack, op_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ack_n     <= 1'b1;
      rdata_oe  <= 1'b0;
      rdata     <= '0;
      be_rd     <= 1'b0;
      be_wr     <= 1'b0;
      cir_upd   <= 1'b0;
      be_addr   <= '0;
      be_wdata  <= '0;
      be_mr_sel <= MR1;
      op_rd     <= 1'b0;
      op_iack   <= 1'b0;
      op_be     <= 1'b0;
    end else begin
      be_rd   <= 1'b0;
      be_wr   <= 1'b0;
      cir_upd <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (active) begin
            st        <= ST_ISSUE;
            be_rd     <= acc_rd && (kind == AK_BACKEND);
            be_wr     <= acc_wr && (kind == AK_BACKEND);
            cir_upd   <= iack_cyc;
            be_addr   <= s_addr;
            be_wdata  <= s_data;
            be_mr_sel <= ptr_cur;
            op_rd     <= acc_rd;
            op_iack   <= iack_cyc;
            op_be     <= (kind == AK_BACKEND);
          end
        end
        ST_ISSUE: begin
          st       <= ST_HOLD;
          ack_n    <= ~ack_en;
          rdata_oe <= op_rd | op_iack;
          if (op_iack)
            rdata <= irq_vec;
          else if (op_rd && op_be)
            rdata <= be_rdata;
          else
            rdata <= '0;
        end
        ST_HOLD: begin
          if (!active) begin
            st       <= ST_IDLE;
            ack_n    <= 1'b1;
            rdata_oe <= 1'b0;
            rdata    <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/quart_host_if_chk.sv
module quart_host_if_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              be_rd,
  input logic              be_wr,
  input logic              cir_upd,
  input logic [1:0]        be_mr_sel,
  input logic              rdata_oe,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] irq_vec,
  input logic              clk_div2,
  input logic              core_ce
);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({be_rd, be_wr, cir_upd}));

  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    be_rd |=> !be_rd);

  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    be_wr |=> !be_wr);

  p_ptr_range_r9: assert property (@(posedge clk) disable iff (rst)
    (be_rd || be_wr) |-> (be_mr_sel != 2'd3));

  p_vec_drive_r8: assert property (@(posedge clk) disable iff (rst)
    cir_upd |=> (rdata_oe && (rdata == $past(irq_vec))));

  p_div1_ce_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!clk_div2) |-> core_ce);

  p_div2_alt_r7: assert property (@(posedge clk) disable iff (rst)
    $past(clk_div2) |-> (core_ce != $past(core_ce)));

endmodule

bind quart_host_if quart_host_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .be_rd(be_rd), .be_wr(be_wr), .cir_upd(cir_upd),
  .be_mr_sel(be_mr_sel), .rdata_oe(rdata_oe), .rdata(rdata), .irq_vec(irq_vec),
  .clk_div2(clk_div2), .core_ce(core_ce)
);

// File: tb/quart_host_if_tb.sv
module quart_host_if_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, iack_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe, ack_n, cir_upd, be_rd, be_wr;
  logic [7:0] irq_vec = 8'hC7;
  logic [5:0] be_addr;
  logic [1:0] be_mr_sel;
  logic [7:0] be_wdata, be_rdata;
  logic       pwr_down, ack_en, clk_div2, baud_hi, core_ce;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign be_rdata = {be_addr, be_mr_sel} ^ 8'h3C;

  quart_host_if u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .iack_n(iack_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .ack_n(ack_n),
    .irq_vec(irq_vec), .cir_upd(cir_upd), .be_rd(be_rd), .be_wr(be_wr),
    .be_addr(be_addr), .be_mr_sel(be_mr_sel), .be_wdata(be_wdata), .be_rdata(be_rdata),
    .pwr_down(pwr_down), .ack_en(ack_en), .clk_div2(clk_div2), .baud_hi(baud_hi),
    .core_ce(core_ce)
  );

  // recorded observations of the last access
  logic       r_rd, r_wr, r_cir, r_rd2, r_ack, r_oe, r_ack_rel, r_oe_rel;
  logic [5:0] r_addr;
  logic [1:0] r_sel;
  logic [7:0] r_wd, r_rdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // kind: 0 read, 1 write, 2 interrupt acknowledge
  task automatic acc(input int kind, input logic csn, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = csn; addr = a; wdata = d;
    rd_n = (kind == 0) ? 1'b0 : 1'b1;
    wr_n = (kind == 1) ? 1'b0 : 1'b1;
    iack_n = (kind == 2) ? 1'b0 : 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    r_rd = be_rd; r_wr = be_wr; r_cir = cir_upd;
    r_addr = be_addr; r_sel = be_mr_sel; r_wd = be_wdata;
    @(posedge clk); @(negedge clk);
    r_ack = ack_n; r_oe = rdata_oe; r_rdata = rdata; r_rd2 = be_rd | be_wr;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; iack_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    r_ack_rel = ack_n; r_oe_rel = rdata_oe;
  endtask

  task automatic t_reset;
    chk(ack_n == 1'b1, "R1 ack_n", int'(ack_n), 1);
    chk(rdata_oe == 1'b0, "R1 rdata_oe", int'(rdata_oe), 0);
    chk({pwr_down, clk_div2, baud_hi} == 3'b000, "R1 global state", int'({pwr_down, clk_div2, baud_hi}), 0);
    chk(ack_en == 1'b1 && core_ce == 1'b1, "R1 ack_en/core_ce", int'({ack_en, core_ce}), 3);
  endtask

  task automatic t_rw_basic;
    acc(0, 1'b0, 6'h01, 8'h00);
    chk(r_rd && !r_wr && r_addr == 6'h01, "R2 read strobe", int'({r_rd, r_wr, r_addr}), int'({2'b10, 6'h01}));
    chk(r_ack == 1'b0 && r_oe && r_rdata == 8'h3C ^ {6'h01, r_sel}, "R2 read data/ack", int'(r_rdata), int'(8'h3C ^ {6'h01, r_sel}));
    chk(r_rd2 == 1'b0, "R2 single pulse on held strobe", int'(r_rd2), 0);
    chk(r_ack_rel && !r_oe_rel, "R4 release after read", int'({r_ack_rel, r_oe_rel}), 2);
    acc(1, 1'b0, 6'h09, 8'hA7);
    chk(r_wr && !r_rd && r_addr == 6'h09 && r_wd == 8'hA7, "R2 write strobe", int'({r_addr, r_wd}), int'({6'h09, 8'hA7}));
    chk(r_ack == 1'b0 && r_oe == 1'b0, "R4 write ack without drive", int'({r_ack, r_oe}), 0);
    chk(r_ack_rel == 1'b1, "R4 release after write", int'(r_ack_rel), 1);
  endtask

  task automatic t_maps;
    acc(0, 1'b0, 6'h12, 8'h00);
    chk(!r_rd && r_oe && r_rdata == 8'h00 && r_ack == 1'b0, "R3 reserved read offset 2", int'({r_rd, r_rdata}), 0);
    acc(1, 1'b0, 6'h12, 8'h55);
    chk(r_wr && r_addr == 6'h12, "R3 write offset 2 forwarded", int'({r_wr, r_addr}), int'({1'b1, 6'h12}));
    acc(1, 1'b0, 6'h0F, 8'h11);
    chk(!r_wr && r_ack == 1'b0, "R3 reserved write 0x0F", int'({r_wr, r_ack}), 0);
    acc(0, 1'b0, 6'h1F, 8'h00);
    chk(r_rd && r_rdata == (8'h3C ^ {6'h1F, r_sel}), "R3 read 0x1F forwarded", int'(r_rdata), int'(8'h3C ^ {6'h1F, r_sel}));
    acc(1, 1'b0, 6'h28, 8'hFF);
    chk(!r_wr && r_ack == 1'b0, "R3 reserved write 0x28", int'({r_wr, r_ack}), 0);
    acc(1, 1'b0, 6'h39, 8'hFF);
    chk(!r_wr && {pwr_down, clk_div2, baud_hi, ack_en} == 4'b0001, "R3 reserved write 0x39 no effect",
        int'({r_wr, pwr_down, clk_div2, baud_hi, ack_en}), 1);
    acc(0, 1'b0, 6'h24, 8'h00);
    chk(!r_rd && r_rdata == 8'h00 && r_oe, "R3 reserved read 0x24", int'({r_rd, r_rdata}), 0);
    acc(0, 1'b0, 6'h2A, 8'h00);
    chk(r_rd && r_addr == 6'h2A, "R3 global read forwarded", int'({r_rd, r_addr}), int'({1'b1, 6'h2A}));
  endtask

  task automatic t_ack_ctrl;
    acc(1, 1'b0, 6'h26, 8'h00);
    chk(r_ack == 1'b1 && !ack_en && !r_wr, "R5 disable write not acknowledged", int'({r_ack, ack_en, r_wr}), 4);
    acc(0, 1'b0, 6'h01, 8'h00);
    chk(r_ack == 1'b1 && r_rd && r_oe, "R5 access works while ack off", int'({r_ack, r_rd, r_oe}), 7);
    acc(1, 1'b0, 6'h27, 8'h00);
    chk(r_ack == 1'b0 && ack_en, "R5 enable write acknowledged", int'({r_ack, ack_en}), 1);
  endtask

  task automatic t_power;
    acc(1, 1'b0, 6'h24, 8'h00);
    chk(pwr_down && !r_wr && r_ack == 1'b0, "R6 power down", int'({pwr_down, r_wr}), 2);
    acc(1, 1'b0, 6'h25, 8'hFF);
    chk(!pwr_down && !r_wr, "R6 power up", int'({pwr_down, r_wr}), 0);
  endtask

  task automatic t_div;
    logic prev;
    acc(1, 1'b0, 6'h2E, 8'h00);
    chk(clk_div2 && !r_wr, "R7 divide by two set", int'(clk_div2), 1);
    @(negedge clk); prev = core_ce;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(core_ce != prev, "R7 core_ce alternates", int'(core_ce), int'(!prev));
      prev = core_ce;
    end
    acc(1, 1'b0, 6'h2F, 8'h00);
    chk(!clk_div2, "R7 divide by one restored", int'(clk_div2), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(core_ce == 1'b1, "R7 core_ce steady", int'(core_ce), 1);
    end
  endtask

  task automatic t_iack;
    irq_vec = 8'hC7;
    acc(2, 1'b1, 6'h00, 8'h00);
    chk(r_cir && !r_rd && !r_wr, "R8 cir update pulse", int'({r_cir, r_rd, r_wr}), 4);
    chk(r_oe && r_rdata == 8'hC7 && r_ack == 1'b0, "R8 vector driven", int'(r_rdata), 8'hC7);
    acc(2, 1'b0, 6'h00, 8'h00);
    chk(!r_cir && r_ack && !r_oe, "R8 iack ignored with cs low", int'({r_cir, r_ack, r_oe}), 2);
  endtask

  task automatic t_mode_ptr;
    acc(0, 1'b0, 6'h00, 8'h00);
    chk(r_sel == 2'd1, "R1 R9 first mode access MR1", int'(r_sel), 1);
    chk(r_rdata == (8'h3C ^ 8'h01), "R9 mode read data", int'(r_rdata), int'(8'h3C ^ 8'h01));
    acc(1, 1'b0, 6'h00, 8'h5A);
    chk(r_sel == 2'd2 && r_wr, "R9 second access MR2", int'(r_sel), 2);
    acc(0, 1'b0, 6'h00, 8'h00);
    chk(r_sel == 2'd2, "R9 pointer stays at MR2", int'(r_sel), 2);
    acc(0, 1'b0, 6'h10, 8'h00);
    chk(r_sel == 2'd1, "R9 channel c independent", int'(r_sel), 1);
    acc(1, 1'b0, 6'h18, 8'h00);
    chk(r_sel == 2'd1, "R9 channel d independent", int'(r_sel), 1);
  endtask

  task automatic t_ptr_cmd;
    acc(1, 1'b0, 6'h02, 8'hB0);
    chk(r_wr && r_addr == 6'h02, "R10 pointer command forwarded", int'({r_wr, r_addr}), int'({1'b1, 6'h02}));
    acc(0, 1'b0, 6'h00, 8'h00);
    chk(r_sel == 2'd0, "R10 pointer to MR0", int'(r_sel), 0);
    acc(0, 1'b0, 6'h00, 8'h00);
    chk(r_sel == 2'd1, "R10 MR0 steps to MR1", int'(r_sel), 1);
    acc(0, 1'b0, 6'h00, 8'h00);
    acc(1, 1'b0, 6'h02, 8'h10);
    acc(0, 1'b0, 6'h00, 8'h00);
    chk(r_sel == 2'd1, "R10 pointer to MR1", int'(r_sel), 1);
  endtask

  task automatic t_baud;
    acc(1, 1'b0, 6'h2D, 8'h01);
    chk(baud_hi && !r_wr, "R11 high baud rate", int'({baud_hi, r_wr}), 2);
    acc(1, 1'b0, 6'h2D, 8'h00);
    chk(!baud_hi, "R11 low baud rate", int'(baud_hi), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_ptr();
    t_rw_basic();
    t_maps();
    t_ack_ctrl();
    t_power();
    t_div();
    t_iack();
    t_ptr_cmd();
    t_baud();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule